// File: doc/BRIEF.md
# Escape-Prefix Opcode Byte Decoder

This block takes instruction bytes one at a time, one per cycle, over a valid/ready byte stream. The stream is fed from the decoder's own instruction pointer. The pointer starts at address 1 after reset and moves forward by one for every byte the decoder accepts. Three escape bytes lengthen an opcode:

- 0x0F opens a two-byte opcode.
- 0xF2 and 0xF3 also open a two-byte opcode. If the byte after either of them is 0x0F, the opcode grows to three bytes.

Which final bytes are legal in each class is set by parameter bitmaps, one bit per byte value.

When an opcode is complete, the decoder presents it for one cycle. It gives the opcode bytes and a length class of 1, 2 or 3. It then goes back to expecting a first byte. The halt byte 0xF4 decodes as a one-byte opcode and loads the pointer with the end-of-program address. A byte that is not recognised at any position raises an error naming that position and the byte. After a halt or an error the decoder accepts no further bytes until reset.

Top module: `opc_esc_decoder`

## Requirements
- R1: After reset, `fetch_addr_o` is 1, `byte_ready_o` is 1, and `op_valid_o`, `err_o` and `halted_o` are 0. `op_len_o`, `op_code_o`, `err_pos_o` and `err_byte_o` are 0.
- R2: Each accepted byte (`byte_valid_i` and `byte_ready_o` both high at a clock edge) that is not the halt byte makes `fetch_addr_o` one larger after that edge.
- R3: A first byte that is set in the one-byte map completes an opcode. On the following cycle `op_valid_o` is 1 and `op_len_o` is 1. `op_code_o[7:0]` holds the byte and `op_code_o[23:8]` is 0.
- R4: A first byte 0x0F followed by a byte set in the 0x0F map gives `op_len_o` = 2, with `op_code_o[7:0]` = 0x0F and `op_code_o[15:8]` = the second byte.
- R5: A first byte 0xF2 or 0xF3 followed by a byte set in that prefix's two-byte map gives `op_len_o` = 2. If it is instead followed by 0x0F and then a byte set in that prefix's three-byte map, `op_len_o` = 3 and `op_code_o[23:16]` = the third byte.
- R6: The first byte 0xF4 gives `op_valid_o` with length 1 and code 0xF4. On the cycle after its acceptance, `fetch_addr_o` equals `end_addr_i` and `halted_o` is 1. From then on `byte_ready_o` is 0 and `fetch_addr_o` does not change.
- R7: An unrecognised byte at position p (1, 2 or 3) produces no `op_valid_o`. On the following cycle `err_o` = 1, `err_pos_o` = p and `err_byte_o` = that byte. After that, `byte_ready_o` stays 0 and the error outputs hold until reset.
- R8: While `byte_valid_i` is 0, the pointer and the partial opcode are held. A stalled multi-byte opcode completes normally once bytes resume.
- R9: `op_valid_o` is high for exactly one cycle per completed opcode. One-byte opcodes accepted on consecutive cycles give `op_valid_o` on consecutive cycles.
- R10: A reset after an error or a halt returns every output to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| end_addr_i | input | AW | Address loaded into the pointer by halt |
| byte_valid_i | input | 1 | Byte on `byte_i` is valid |
| byte_i | input | 8 | Instruction byte read at `fetch_addr_o` |
| byte_ready_o | output | 1 | Decoder accepts a byte this cycle |
| fetch_addr_o | output | AW | Instruction pointer |
| op_valid_o | output | 1 | One-cycle strobe for a decoded opcode |
| op_len_o | output | 2 | Opcode length class, 1 to 3 |
| op_code_o | output | 24 | Opcode bytes, first byte in [7:0] |
| halted_o | output | 1 | Halt decoded; decoder stopped |
| err_o | output | 1 | Unrecognised byte; decoder stopped |
| err_pos_o | output | 2 | Failing byte position, 1 to 3 |
| err_byte_o | output | 8 | The failing byte |

## Verification
The main stream is a long run that mixes plain one-byte opcodes, every escape path (0x0F, 0xF2/0xF3 two-byte, and 0xF2/0xF3 followed by 0x0F), and a final halt:

- Run back to back, it separates length classes that only look alike at the first byte, and it shows the return to first-byte state between opcodes.
- Run again with `byte_valid_i` dropped on a regular pattern, it shows that a stall in the middle of an opcode loses neither the stored prefix nor the pointer.

Separate short streams fail at the first, second and third positions, including an 0xF2 prefix followed by a byte missing from its map. These show that the reported position follows the stage at which the lookup failed, and not merely the byte value.

// File: rtl/opc_esc_pkg.sv
package opc_esc_pkg;
  typedef enum logic [1:0] {ST_B0 = 2'd0, ST_B1 = 2'd1, ST_B2 = 2'd2, ST_STOP = 2'd3} stage_e;
  typedef enum logic [1:0] {ACT_MORE, ACT_DONE, ACT_HALT, ACT_BAD} act_e;

  localparam logic [7:0] ESC_0F   = 8'h0F;
  localparam logic [7:0] ESC_F2   = 8'hF2;
  localparam logic [7:0] ESC_F3   = 8'hF3;
  localparam logic [7:0] OPC_HALT = 8'hF4;

  function automatic logic [255:0] bit_of(input logic [7:0] b);
    return 256'(1) << b;
  endfunction
endpackage

// File: rtl/opc_esc_ptr.sv
module opc_esc_ptr #(
  parameter int unsigned AW       = 32,
  parameter int unsigned RESET_IP = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] ip_o
);
  localparam logic [AW-1:0] IpInit = AW'(RESET_IP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ip_o <= IpInit;
    else if (load_i) ip_o <= load_val_i;
    else if (step_i) ip_o <= ip_o + AW'(1);
  end

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ip_o == $past(ip_o) + AW'(1));
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ip_o == $past(load_val_i));
endmodule

// File: rtl/opc_esc_lookup.sv
module opc_esc_lookup
  import opc_esc_pkg::*;
#(
  parameter logic [255:0] ONE_MAP   = '0,
  parameter logic [255:0] MAP_0F    = '0,
  parameter logic [255:0] MAP_F2    = '0,
  parameter logic [255:0] MAP_F3    = '0,
  parameter logic [255:0] MAP_F2_0F = '0,
  parameter logic [255:0] MAP_F3_0F = '0
) (
  input  stage_e     stage_i,
  input  logic [7:0] lead_i,
  input  logic [7:0] byte_i,
  output act_e       act_o
);
  logic [255:0] map_two, map_three;

  // pick the per-prefix tables
  always_comb begin
    unique case (lead_i)
      ESC_F2:  begin map_two = MAP_F2; map_three = MAP_F2_0F; end
      ESC_F3:  begin map_two = MAP_F3; map_three = MAP_F3_0F; end
      default: begin map_two = MAP_0F; map_three = '0;        end
    endcase
  end

  always_comb begin
    act_o = ACT_BAD;
    unique case (stage_i)
      ST_B0: begin
        if (byte_i == ESC_0F || byte_i == ESC_F2 || byte_i == ESC_F3) act_o = ACT_MORE;
        else if (byte_i == OPC_HALT)                                    act_o = ACT_HALT;
        else if (ONE_MAP[byte_i])                                       act_o = ACT_DONE;
      end
      ST_B1: begin
        if (lead_i != ESC_0F && byte_i == ESC_0F) act_o = ACT_MORE;
        else if (map_two[byte_i])                 act_o = ACT_DONE;
      end
      ST_B2: if (map_three[byte_i]) act_o = ACT_DONE;
      default: act_o = ACT_BAD;
    endcase
  end
endmodule

// File: rtl/opc_esc_fsm.sv
module opc_esc_fsm
  import opc_esc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        take_i,
  input  logic [7:0]  byte_i,
  input  act_e        act_i,
  output stage_e      stage_o,
  output logic [7:0]  lead_o,
  output logic        ready_o,
  output logic        op_valid_o,
  output logic [1:0]  op_len_o,
  output logic [23:0] op_code_o,
  output logic        halted_o,
  output logic        err_o,
  output logic [1:0]  err_pos_o,
  output logic [7:0]  err_byte_o
);
  stage_e     stage_q;
  logic [7:0] lead_q, mid_q;
  logic [1:0] pos;

  assign stage_o = stage_q;
  assign lead_o  = lead_q;
  assign ready_o = (stage_q != ST_STOP);
  assign pos     = 2'(stage_q) + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q    <= ST_B0;
      lead_q     <= '0;
      mid_q      <= '0;
      op_valid_o <= 1'b0;
      op_len_o   <= '0;
      op_code_o  <= '0;
      halted_o   <= 1'b0;
      err_o      <= 1'b0;
      err_pos_o  <= '0;
      err_byte_o <= '0;
    end else begin
      op_valid_o <= 1'b0;
      if (take_i) begin
        unique case (act_i)
          ACT_MORE: begin
            if (stage_q == ST_B0) begin lead_q <= byte_i; stage_q <= ST_B1; end
            else                  begin mid_q  <= byte_i; stage_q <= ST_B2; end
          end
          ACT_DONE: begin
            op_valid_o <= 1'b1;
            op_len_o   <= pos;
            unique case (stage_q)
              ST_B0:   op_code_o <= {16'h0, byte_i};
              ST_B1:   op_code_o <= {8'h0, byte_i, lead_q};
              default: op_code_o <= {byte_i, mid_q, lead_q};
            endcase
            stage_q <= ST_B0;
          end
          ACT_HALT: begin
            op_valid_o <= 1'b1;
            op_len_o   <= 2'd1;
            op_code_o  <= {16'h0, byte_i};
            halted_o   <= 1'b1;
            stage_q    <= ST_STOP;
          end
          default: begin
            err_o      <= 1'b1;
            err_pos_o  <= pos;
            err_byte_o <= byte_i;
            stage_q    <= ST_STOP;
          end
        endcase
      end
    end
  end

  a_r7_stop_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o || halted_o) |-> !ready_o);
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (err_o && $stable(err_pos_o) && $stable(err_byte_o)));
  a_r7_pos_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_pos_o != 2'd0);
  a_r7_no_op_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !op_valid_o);
  a_r3_len_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> op_len_o != 2'd0);
endmodule

// File: rtl/opc_esc_decoder.sv
module opc_esc_decoder
  import opc_esc_pkg::*;
#(
  parameter int unsigned  AW        = 32,
  parameter int unsigned  RESET_IP  = 1,
  parameter logic [255:0] ONE_MAP   = bit_of(8'h01) | bit_of(8'h05) | bit_of(8'h90) | bit_of(8'hC3),
  parameter logic [255:0] MAP_0F    = bit_of(8'h84) | bit_of(8'h85) | bit_of(8'hAF),
  parameter logic [255:0] MAP_F2    = bit_of(8'h10),
  parameter logic [255:0] MAP_F3    = bit_of(8'h90),
  parameter logic [255:0] MAP_F2_0F = bit_of(8'h58),
  parameter logic [255:0] MAP_F3_0F = bit_of(8'h2A)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] end_addr_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_i,
  output logic          byte_ready_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          op_valid_o,
  output logic [1:0]    op_len_o,
  output logic [23:0]   op_code_o,
  output logic          halted_o,
  output logic          err_o,
  output logic [1:0]    err_pos_o,
  output logic [7:0]    err_byte_o
);
  stage_e     stage;
  logic [7:0] lead;
  act_e       act;
  logic       take;

  assign take = byte_valid_i && byte_ready_o;

  opc_esc_lookup #(
    .ONE_MAP(ONE_MAP), .MAP_0F(MAP_0F), .MAP_F2(MAP_F2), .MAP_F3(MAP_F3),
    .MAP_F2_0F(MAP_F2_0F), .MAP_F3_0F(MAP_F3_0F)
  ) u_lookup (
    .stage_i(stage), .lead_i(lead), .byte_i(byte_i), .act_o(act)
  );

  opc_esc_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .byte_i(byte_i), .act_i(act),
    .stage_o(stage), .lead_o(lead), .ready_o(byte_ready_o),
    .op_valid_o(op_valid_o), .op_len_o(op_len_o), .op_code_o(op_code_o),
    .halted_o(halted_o), .err_o(err_o), .err_pos_o(err_pos_o), .err_byte_o(err_byte_o)
  );

  opc_esc_ptr #(.AW(AW), .RESET_IP(RESET_IP)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .step_i(take && act != ACT_HALT),
    .load_i(take && act == ACT_HALT),
    .load_val_i(end_addr_i),
    .ip_o(fetch_addr_o)
  );

  a_r6_ip_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(fetch_addr_o));
  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> $stable(fetch_addr_o));
endmodule

// File: tb/opc_esc_decoder_tb.sv
module opc_esc_decoder_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] END_ADDR = 32'd100;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic byte_ready_o, op_valid_o, halted_o, err_o;
  logic [AW-1:0] fetch_addr_o;
  logic [1:0] op_len_o, err_pos_o;
  logic [23:0] op_code_o;
  logic [7:0] err_byte_o;

  always #2.5 clk = ~clk;

  opc_esc_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .end_addr_i(END_ADDR),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .byte_ready_o(byte_ready_o),
    .fetch_addr_o(fetch_addr_o), .op_valid_o(op_valid_o), .op_len_o(op_len_o),
    .op_code_o(op_code_o), .halted_o(halted_o), .err_o(err_o),
    .err_pos_o(err_pos_o), .err_byte_o(err_byte_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit gaps = 0, run = 0;
  logic [7:0] mem [256];

  // reference model state
  int m_stage; bit m_stop, m_valid, m_halt, m_err;
  logic [31:0] m_ip; logic [7:0] m_b0, m_b1, m_ebyte;
  int m_len, m_pos; logic [23:0] m_code;

  function automatic bit in_one(logic [7:0] b);
    return b == 8'h01 || b == 8'h05 || b == 8'h90 || b == 8'hC3;
  endfunction
  function automatic bit in_two(logic [7:0] p, logic [7:0] b);
    if (p == 8'h0F) return b == 8'h84 || b == 8'h85 || b == 8'hAF;
    if (p == 8'hF2) return b == 8'h10;
    return b == 8'h90;
  endfunction
  function automatic bit in_three(logic [7:0] p, logic [7:0] b);
    return (p == 8'hF2) ? (b == 8'h58) : (b == 8'h2A);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic m_reset();
    m_stage = 0; m_stop = 0; m_valid = 0; m_halt = 0; m_err = 0;
    m_ip = 32'd1; m_b0 = 0; m_b1 = 0; m_ebyte = 0; m_len = 0; m_pos = 0; m_code = 0;
  endtask

  task automatic m_bad(logic [7:0] b);
    m_err = 1; m_pos = m_stage + 1; m_ebyte = b; m_stop = 1;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) m_reset();
    else begin
      m_valid = 0;
      if (byte_valid_i && !m_stop) begin
        logic [7:0] b;
        b = byte_i;
        m_ip = m_ip + 1;
        if (m_stage == 0) begin
          if (b == 8'h0F || b == 8'hF2 || b == 8'hF3) begin m_b0 = b; m_stage = 1; end
          else if (b == 8'hF4) begin
            m_valid = 1; m_len = 1; m_code = 24'hF4; m_halt = 1; m_stop = 1; m_ip = END_ADDR;
          end else if (in_one(b)) begin m_valid = 1; m_len = 1; m_code = {16'h0, b}; end
          else m_bad(b);
        end else if (m_stage == 1) begin
          if (m_b0 != 8'h0F && b == 8'h0F) begin m_b1 = b; m_stage = 2; end
          else if (in_two(m_b0, b)) begin
            m_valid = 1; m_len = 2; m_code = {8'h0, b, m_b0}; m_stage = 0;
          end else m_bad(b);
        end else begin
          if (in_three(m_b0, b)) begin
            m_valid = 1; m_len = 3; m_code = {b, m_b1, m_b0}; m_stage = 0;
          end else m_bad(b);
        end
      end
    end
  end

  // compare every cycle, then drive the next byte
  always @(negedge clk) begin
    cyc++;
    if (run && rst_ni) begin
      string rq;
      chk("R2/R8", "fetch_addr", fetch_addr_o, m_ip);
      chk(m_err ? "R7" : (m_halt ? "R6" : "R8"), "ready", 32'(byte_ready_o), 32'(!m_stop));
      chk("R9", "op_valid", 32'(op_valid_o), 32'(m_valid));
      if (m_valid) begin
        if (m_code == 24'hF4) rq = "R6";
        else if (m_len == 1) rq = "R3";
        else if (m_len == 2 && m_code[7:0] == 8'h0F) rq = "R4";
        else rq = "R5";
        chk(rq, "op_len", 32'(op_len_o), 32'(m_len));
        chk(rq, "op_code", 32'(op_code_o), 32'(m_code));
      end
      chk("R6", "halted", 32'(halted_o), 32'(m_halt));
      chk("R7", "err", 32'(err_o), 32'(m_err));
      if (m_err) begin
        chk("R7", "err_pos", 32'(err_pos_o), 32'(m_pos));
        chk("R7", "err_byte", 32'(err_byte_o), 32'(m_ebyte));
      end
    end
    byte_valid_i <= gaps ? (cyc % 3 != 2) : 1'b1;
    byte_i       <= mem[m_ip[7:0]];
  end

  task automatic load(input logic [7:0] s []);
    foreach (mem[i]) mem[i] = 8'h00;
    foreach (s[i]) mem[i + 1] = s[i];
  endtask

  task automatic reset_and_check(string req);
    run = 0;
    @(negedge clk); rst_ni = 0;
    @(negedge clk); @(negedge clk);
    chk(req, "rst fetch_addr", fetch_addr_o, 32'd1);
    chk(req, "rst ready", 32'(byte_ready_o), 32'd1);
    chk(req, "rst op_valid", 32'(op_valid_o), 32'd0);
    chk(req, "rst err", 32'(err_o), 32'd0);
    chk(req, "rst halted", 32'(halted_o), 32'd0);
    chk(req, "rst len/code", {6'h0, op_len_o, op_code_o}, 32'd0);
    chk(req, "rst err info", {22'h0, err_pos_o, err_byte_o}, 32'd0);
    rst_ni = 1; run = 1;
  endtask

  task automatic go(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // mixed stream covering R3 R4 R5 and final halt R6
    load('{8'h90, 8'h0F, 8'h84, 8'hF2, 8'h10, 8'hF3, 8'h0F, 8'h2A, 8'hF2, 8'h0F, 8'h58,
           8'h01, 8'hC3, 8'hF3, 8'h90, 8'h05, 8'h0F, 8'hAF, 8'hF4, 8'h90});
    gaps = 0; reset_and_check("R1"); go(40);
    // same stream with stalls (R8)
    gaps = 1; reset_and_check("R1"); go(60);
    gaps = 0;
    // R7 failures at each position, then R10 recovery via reset
    load('{8'h90, 8'h77, 8'h01}); reset_and_check("R10"); go(15);
    load('{8'h05, 8'h0F, 8'h33});  reset_and_check("R10"); go(15);
    load('{8'hF2, 8'h55});        reset_and_check("R10"); go(15);
    gaps = 1;
    load('{8'hF3, 8'h0F, 8'h99}); reset_and_check("R10"); go(20);
    gaps = 0;
    load('{8'hF2, 8'h0F, 8'h2A}); reset_and_check("R10"); go(15);
    // back-to-back one-byte opcodes, halt right after (R9)
    load('{8'h01, 8'h05, 8'h90, 8'hC3, 8'hF4}); reset_and_check("R10"); go(15);
    run = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule